// File: doc/BRIEF.md
# Prioritized Bus Grant Arbiter

This block decides which peripheral may take the bus away from the processor. Peripherals raise one of four interrupt request lines, ranked at levels 4 through 7, or a single direct-memory request. The arbiter compares each interrupt level against the processor's current priority. Interrupts are only considered when an instruction completes. A memory request is passed through an enable made of three processor-side conditions. Exactly one grant is driven at a time.

Once a grant is out, the arbiter waits for the device to answer with a selection acknowledge. An answer ends the grant and reports which level was served. If no answer arrives within a fixed time window, the grant is withdrawn and a cancel pulse tells the processor to carry on. A new grant waits until the acknowledge line has been released.

Top module: `busgrant_arbiter`

## Requirements
- R1: Interrupt request bit i stands for level 4+i and maps to grant bit i. Among eligible requests, the highest level is granted.
- R2: An interrupt level is eligible only when it is strictly greater than `cpu_pri`. With `cpu_pri` at 7, no interrupt is ever granted.
- R3: Interrupt grants are decided only in an idle cycle where `insn_done` is high. The grant is visible in the cycle after that edge.
- R4: `dma_req` is registered once before use. A memory grant is set at an edge only when the registered request is high, `rmw_busy` is low, `cpu_run` is high, and the registered copy of `sel_ack` is low. The grant therefore appears two edges after the request.
- R5: When the memory-grant condition holds in an idle cycle, it wins over any eligible interrupt.
- R6: All grants come from flip-flops, and at most one of `grant_irq` and `grant_dma` is high in any cycle.
- R7: A grant that sees no acknowledge is held for exactly TIMEOUT_NS/CLK_PERIOD_NS cycles and then dropped. `grant_cancel` is high for the single cycle that follows.
- R8: When `sel_ack` is sampled high during a grant, the grant drops at that edge. At the same edge `served_lvl` takes the granted level (4..7 for interrupts, 0 for memory), and `served_stb` pulses for one cycle.
- R9: After an acknowledge, no grant of any kind is issued while `sel_ack` stays high.
- R10: While reset is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 4 | Interrupt requests, bit i is level 4+i |
| dma_req | input | 1 | Direct memory request |
| cpu_pri | input | 3 | Processor priority field |
| insn_done | input | 1 | Instruction boundary strobe |
| rmw_busy | input | 1 | Read-with-pause cycle in progress |
| cpu_run | input | 1 | Processor is running |
| sel_ack | input | 1 | Selection acknowledge from the device |
| grant_irq | output | 4 | One-hot interrupt grants |
| grant_dma | output | 1 | Memory grant |
| grant_cancel | output | 1 | One-cycle pulse when an unanswered grant is withdrawn |
| served_lvl | output | 3 | Level of the last acknowledged grant |
| served_stb | output | 1 | One-cycle pulse when `served_lvl` updates |

## Verification
A wrong priority pick or mask compare shows up as the wrong grant bit one edge after the boundary strobe. The bench sweeps all request patterns against all eight priorities to catch it. A faulty memory enable or request register shows up two edges after the request, as a grant that is present when it should be absent, or the reverse. A timer that is off by one moves the cancel pulse by one cycle, and a missing hold state lets a grant reappear while acknowledge is still high. All of these are visible within a handful of cycles, except the timeout, which needs the full window.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  localparam int unsigned NLVL   = 4;
  localparam int unsigned BASE   = 4;
  localparam int unsigned LVL_W  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_GRANT, ST_HOLD} arb_state_e;

  // level number carried by a one-hot interrupt grant
  function automatic logic [LVL_W-1:0] level_of(input logic [NLVL-1:0] oh);
    logic [LVL_W-1:0] l;
    l = '0;
    for (int i = 0; i < NLVL; i++)
      if (oh[i]) l = LVL_W'(BASE + i);
    return l;
  endfunction

  // true when level index i beats the processor priority
  function automatic logic beats(input int unsigned i, input logic [LVL_W-1:0] pri);
    return (BASE + i) > int'(pri);
  endfunction
endpackage

// File: rtl/busarb_pick.sv
module busarb_pick
  import busarb_pkg::*;
(
  input  logic [NLVL-1:0]  req,
  input  logic [LVL_W-1:0] pri,
  output logic [NLVL-1:0]  win,
  output logic             win_any
);
  logic [NLVL-1:0] elig;

  for (genvar g = 0; g < NLVL; g++) begin : g_elig
    assign elig[g] = req[g] & beats(g, pri);
  end

  always_comb begin
    win = '0;
    for (int i = 0; i < NLVL; i++)
      if (elig[i]) win = NLVL'(1) << i;
  end

  assign win_any = |elig;
endmodule

// File: rtl/busarb_dma_gate.sv
module busarb_dma_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic rmw_busy,
  input  logic cpu_run,
  input  logic sel_ack,
  output logic dma_ok
);
  logic dma_pend, ack_dly;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_pend <= 1'b0;
      ack_dly  <= 1'b0;
    end else begin
      dma_pend <= dma_req;
      ack_dly  <= sel_ack;
    end
  end

  assign dma_ok = dma_pend & ~rmw_busy & ~ack_dly & cpu_run;
endmodule

// File: rtl/busarb_timer.sv
module busarb_timer #(
  parameter int unsigned LIMIT = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (run && !expire) cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));
endmodule

// File: rtl/busgrant_arbiter.sv
module busgrant_arbiter
  import busarb_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned TIMEOUT_NS    = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLVL-1:0]  irq_req,
  input  logic             dma_req,
  input  logic [LVL_W-1:0] cpu_pri,
  input  logic             insn_done,
  input  logic             rmw_busy,
  input  logic             cpu_run,
  input  logic             sel_ack,
  output logic [NLVL-1:0]  grant_irq,
  output logic             grant_dma,
  output logic             grant_cancel,
  output logic [LVL_W-1:0] served_lvl,
  output logic             served_stb
);
  localparam int unsigned TMO_CYC = TIMEOUT_NS / CLK_PERIOD_NS;

  arb_state_e      state;
  logic [NLVL-1:0] win;
  logic            win_any, dma_ok_w, expire_w, any_grant;

  busarb_pick u_pick (.req(irq_req), .pri(cpu_pri), .win(win), .win_any(win_any));

  busarb_dma_gate u_dma (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .rmw_busy(rmw_busy),
    .cpu_run(cpu_run), .sel_ack(sel_ack), .dma_ok(dma_ok_w));

  busarb_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE),
    .run(state == ST_GRANT), .expire(expire_w));

  assign any_grant = grant_dma | (|grant_irq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      grant_irq    <= '0;
      grant_dma    <= 1'b0;
      grant_cancel <= 1'b0;
      served_lvl   <= '0;
      served_stb   <= 1'b0;
    end else begin
      grant_cancel <= 1'b0;
      served_stb   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (dma_ok_w) begin
            grant_dma <= 1'b1;
            state     <= ST_GRANT;
          end else if (insn_done && win_any) begin
            grant_irq <= win;
            state     <= ST_GRANT;
          end
        end
        ST_GRANT: begin
          if (sel_ack) begin
            served_lvl <= grant_dma ? '0 : level_of(grant_irq);
            served_stb <= 1'b1;
            grant_irq  <= '0;
            grant_dma  <= 1'b0;
            state      <= ST_HOLD;
          end else if (expire_w) begin
            grant_cancel <= 1'b1;
            grant_irq    <= '0;
            grant_dma    <= 1'b0;
            state        <= ST_IDLE;
          end
        end
        ST_HOLD: if (!sel_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_irq, grant_dma}));

  for (genvar g = 0; g < NLVL; g++) begin : g_mask_chk
    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_irq[g]) |-> (int'($past(cpu_pri)) < int'(BASE + g)));
  end

  p_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|grant_irq) |-> $past(insn_done));

  p_dma_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_dma) |-> ($past(cpu_run) && !$past(rmw_busy)
                          && $past(dma_req, 2) && !$past(sel_ack, 2)));

  p_dma_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && dma_ok_w && insn_done && win_any) |=> grant_dma);

  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_cancel |-> ($past(any_grant) && !any_grant));

  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_grant && sel_ack) |=> (!any_grant && served_stb));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && sel_ack) |=> !any_grant);
endmodule

// File: tb/busgrant_arbiter_test.sv
module busgrant_arbiter_test;
  localparam int PER_NS = 8;
  localparam int TMO_NS = 10000;
  localparam int TMO    = TMO_NS / PER_NS;

  logic clk = 0, rst_n = 0;
  logic [3:0] irq_req = 0;
  logic dma_req = 0, insn_done = 0, rmw_busy = 0, cpu_run = 1, sel_ack = 0;
  logic [2:0] cpu_pri = 0;
  logic [3:0] grant_irq;
  logic grant_dma, grant_cancel, served_stb;
  logic [2:0] served_lvl;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  busgrant_arbiter #(.CLK_PERIOD_NS(PER_NS), .TIMEOUT_NS(TMO_NS)) uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .dma_req(dma_req),
    .cpu_pri(cpu_pri), .insn_done(insn_done), .rmw_busy(rmw_busy),
    .cpu_run(cpu_run), .sel_ack(sel_ack), .grant_irq(grant_irq),
    .grant_dma(grant_dma), .grant_cancel(grant_cancel),
    .served_lvl(served_lvl), .served_stb(served_stb));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expect_win(input logic [3:0] rq, input int pri);
    logic [3:0] w = 0;
    for (int lvl = 7; lvl >= 4; lvl--)
      if (w == 0 && rq[lvl-4] && lvl > pri) w = 4'(1 << (lvl - 4));
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    irq_req = 4'hF; dma_req = 1; insn_done = 1;
    repeat (3) tick();
    chk("R10 grants in reset", {grant_irq, grant_dma, grant_cancel, served_stb}, 0);
    chk("R10 served_lvl in reset", served_lvl, 0);
    irq_req = 0; dma_req = 0; insn_done = 0;
    tick();
    rst_n = 1;
    tick();

    // R1 R2 sweep: every request pattern against every priority
    for (int p = 0; p < 8; p++) begin
      for (int rq = 0; rq < 16; rq++) begin
        logic [3:0] e;
        e = expect_win(4'(rq), p);
        irq_req = 4'(rq); cpu_pri = 3'(p); insn_done = 1;
        tick();
        insn_done = 0;
        chk($sformatf("R1 R2 pri=%0d req=%0h", p, rq), grant_irq, e);
        chk("R6 single grant", $countones({grant_irq, grant_dma}) <= 1, 1);
        if (e != 0) begin
          int lv;
          lv = 0;
          for (int k = 0; k < 4; k++) if (e[k]) lv = 4 + k;
          sel_ack = 1;
          tick();
          chk("R8 grant drops on ack", grant_irq, 0);
          chk("R8 served level", served_lvl, lv);
          chk("R8 served strobe", served_stb, 1);
          irq_req = 0; sel_ack = 0;
          tick();
          chk("R8 strobe one cycle", served_stb, 0);
        end else irq_req = 0;
      end
    end
    cpu_pri = 0;

    // R3: no interrupt grant without boundary strobe
    irq_req = 4'hF;
    repeat (3) begin tick(); chk("R3 no grant off boundary", grant_irq, 0); end
    insn_done = 1; tick(); insn_done = 0;
    chk("R3 grant at boundary", grant_irq, 4'h8);
    sel_ack = 1; irq_req = 0; tick(); sel_ack = 0; tick();

    // R4: three-term enable for memory grant
    for (int c = 0; c < 4; c++) begin
      logic run_v, rmw_v, exp_g;
      run_v = c[0]; rmw_v = c[1]; exp_g = run_v & ~rmw_v;
      cpu_run = run_v; rmw_busy = rmw_v; dma_req = 1;
      tick();
      chk("R4 no grant before register", grant_dma, 0);
      tick();
      chk($sformatf("R4 run=%0d rmw=%0d", run_v, rmw_v), grant_dma, exp_g);
      if (exp_g) begin
        dma_req = 0; sel_ack = 1; tick();
        chk("R8 memory served level", served_lvl, 0);
        chk("R8 memory served strobe", served_stb, 1);
        sel_ack = 0; tick();
      end else begin
        dma_req = 0; tick();
      end
      cpu_run = 1; rmw_busy = 0;
      tick();
      chk("R4 idle after case", grant_dma, 0);
    end

    // R4: delayed acknowledge blocks memory grant
    sel_ack = 1; dma_req = 1;
    repeat (3) begin tick(); chk("R4 ack delayed blocks", grant_dma, 0); end
    sel_ack = 0; tick();
    chk("R4 still blocked one cycle", grant_dma, 0);
    tick();
    chk("R4 grant after ack release", grant_dma, 1);
    dma_req = 0; sel_ack = 1; tick(); sel_ack = 0; tick();

    // R5: memory request wins over an eligible interrupt
    dma_req = 1; irq_req = 4'h8; tick();
    insn_done = 1; tick(); insn_done = 0;
    chk("R5 memory grant wins", grant_dma, 1);
    chk("R5 no interrupt grant", grant_irq, 0);
    dma_req = 0; irq_req = 0; sel_ack = 1; tick(); sel_ack = 0; tick();

    // R7: timeout withdraws unanswered grant
    irq_req = 4'h2; insn_done = 1; tick(); insn_done = 0; irq_req = 0;
    chk("R7 grant issued", grant_irq, 4'h2);
    repeat (TMO - 1) tick();
    chk("R7 grant held to window end", grant_irq, 4'h2);
    chk("R7 no early cancel", grant_cancel, 0);
    tick();
    chk("R7 grant withdrawn", grant_irq, 0);
    chk("R7 cancel pulse", grant_cancel, 1);
    chk("R7 no served strobe", served_stb, 0);
    tick();
    chk("R7 cancel one cycle", grant_cancel, 0);

    // R9: no grant while acknowledge held
    irq_req = 4'h4; insn_done = 1; tick();
    chk("R9 setup grant", grant_irq, 4'h4);
    irq_req = 4'hF; dma_req = 1; sel_ack = 1;
    tick();
    repeat (4) begin tick(); chk("R9 no grant while ack", {grant_irq, grant_dma}, 0); end
    irq_req = 0; dma_req = 0; insn_done = 0; sel_ack = 0;
    tick(); tick();
    chk("R9 idle after release", {grant_irq, grant_dma}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule